// File: doc/BRIEF.md
# Page-Load Write Buffer for a Byte-Wide Nonvolatile Store

This block is the device-side core of a parallel nonvolatile byte memory. Write strobes arrive synchronously with a 13-bit address and an 8-bit data byte. The first accepted strobe opens a load window and fixes the page it belongs to. Later strobes to the same page drop their bytes into a 64-byte staging buffer and set a per-byte "loaded" flag. A byte written twice keeps the later value, and bytes may arrive in any order.

The window closes once no byte has been accepted for a programmable number of clock cycles. The block then raises `busy` and runs a self-timed programming phase. When that phase ends, exactly the flagged bytes of the page are copied into the on-chip storage array. Every other byte of the page keeps its old contents.

While `busy` is high, a read does not return stored data. It returns a status word instead: the inverse of bit 7 of the last byte loaded, together with a bit that flips on every such read. Host software polls this word to find out when programming has finished. Both time limits are parameters counted in clock cycles, so a fast model can shrink them.

Top module: `page_write_store`

## Requirements
- R1: Address bits [12:6] select the page and bits [5:0] select the byte within it. One programming phase commits between 1 and 64 bytes. The array holds STORE_PAGES pages, and the page number is used modulo STORE_PAGES.
- R2: The first write accepted while idle fixes the open page. A write to any other page during the window is ignored and does not restart the gap timer.
- R3: Suppose a write is accepted on clock edge T and no further write is accepted. The window closes on edge T+GAP_CYC and `busy` is high from then on. A same-page write on edge T+GAP_CYC or earlier is still accepted and keeps the window open.
- R4: Bytes may be loaded in any order. A byte loaded twice in one window commits its latest value.
- R5: Only the bytes loaded in the window are changed in the array. Other bytes of the page keep their previous value.
- R6: `busy` stays high for exactly PROG_CYC cycles. The new contents can be read after `busy` falls.
- R7: Write strobes while `busy` is high are ignored.
- R8: A read while `busy` is high returns a status word. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 is 0 on the first poll after the window closes and flips on each later poll. Bits 5:0 are zero.
- R9: After reset, `busy` is 0, `rdata` is 0x00 and every array byte reads 0xFF.
- R10: A read while not busy returns the array byte at `addr` on `rdata` one clock after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 13 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or status word |
| busy | output | 1 | High from window close until programming completes |

## Verification
A gap counter that runs early or late moves the rising edge of `busy` away from exactly GAP_CYC cycles after the last accepted write. The bench samples that edge on both sides of the boundary. A stale loaded flag or a corrupt staging byte does not show until `busy` falls, and only in a later read of that address. For that reason every committed page is read back, both at loaded offsets and at neighbouring offsets that were not loaded. A fault in the status logic shows on the first two polls after the window closes, as a wrong bit 7 or a bit 6 that does not alternate.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 6;
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam logic [DATA_W-1:0] ERASED = 8'hFF;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PAGE_BYTES-1:0][DATA_W-1:0] page_bytes_t;
    typedef logic [PAGE_BYTES-1:0] page_mask_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        byte_t             data;
    } wr_req_t;

    function automatic wr_req_t make_req(logic [ADDR_W-1:0] a, byte_t d);
        wr_req_t r;
        r.page = a[ADDR_W-1:OFS_W];
        r.ofs  = a[OFS_W-1:0];
        r.data = d;
        return r;
    endfunction
endpackage

// File: rtl/pw_ctrl.sv
`timescale 1ns/1ps
module pw_ctrl
    import pw_pkg::*;
#(
    parameter int GAP_CYC  = 12500,
    parameter int PROG_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [PAGE_W-1:0] open_page,
    output logic              accept,
    output logic              first,
    output logic              loading,
    output logic              close,
    output logic              commit,
    output logic              busy
);
    localparam int MAXC = (GAP_CYC > PROG_CYC) ? GAP_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    assign accept  = wr_en && ((phase == PH_IDLE) ||
                               (phase == PH_LOAD && wr_page == open_page));
    assign first   = accept && (phase == PH_IDLE);
    assign loading = (phase == PH_LOAD);
    assign close   = (phase == PH_LOAD) && !accept && (cnt == GAP_LAST);
    assign commit  = (phase == PH_PROG) && (cnt == PROG_LAST);
    assign busy    = (phase == PH_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (accept) phase <= PH_LOAD;
                end
                PH_LOAD: begin
                    if (accept) begin
                        cnt <= '0;
                    end else if (cnt == GAP_LAST) begin
                        cnt   <= '0;
                        phase <= PH_PROG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (cnt == PROG_LAST) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |-> (cnt <= GAP_LAST)); // R3
    AST_PROG_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PROG) |-> (cnt <= PROG_LAST)); // R6
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy); // R6
endmodule

// File: rtl/pw_stage.sv
`timescale 1ns/1ps
module pw_stage
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              first,
    input  logic              loading,
    input  logic              busy,
    input  logic              wr_en,
    input  wr_req_t           req,
    output logic [PAGE_W-1:0] open_page,
    output page_mask_t        mask,
    output page_bytes_t       bytes,
    output logic              last_b7
);
    always_ff @(posedge clk) begin
        if (rst) begin
            open_page <= '0;
            mask      <= '0;
            bytes     <= '0;
            last_b7   <= 1'b0;
        end else if (accept) begin
            if (first) begin
                open_page <= req.page;
                mask      <= page_mask_t'(1) << req.ofs;
            end else begin
                mask[req.ofs] <= 1'b1;
            end
            bytes[req.ofs] <= req.data;
            last_b7        <= req.data[DATA_W-1];
        end
    end

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(mask)); // R7
    AST_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mask != '0)); // R1
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loading && $past(loading)) |-> $stable(open_page)); // R2
endmodule

// File: rtl/pw_array.sv
`timescale 1ns/1ps
module pw_array
    import pw_pkg::*;
#(
    parameter int STORE_PAGES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              close,
    input  logic              busy,
    input  logic [PAGE_W-1:0] page,
    input  page_mask_t        mask,
    input  page_bytes_t       bytes,
    input  logic              last_b7,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rdata
);
    localparam int DEPTH = STORE_PAGES * PAGE_BYTES;
    localparam int IDX_W = $clog2(DEPTH);

    byte_t mem [DEPTH];
    logic  toggle;

    function automatic logic [IDX_W-1:0] index_of(logic [PAGE_W-1:0] pg,
                                                  logic [OFS_W-1:0]  o);
        int unsigned folded;
        folded = (int'(pg) % STORE_PAGES) * PAGE_BYTES + int'(o);
        return IDX_W'(folded);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (mask[j]) mem[index_of(page, OFS_W'(j))] <= bytes[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            toggle <= 1'b0;
        end else begin
            if (close) toggle <= 1'b0;
            if (rd_en) begin
                if (busy) begin
                    rdata  <= {~last_b7, toggle, {(DATA_W-2){1'b0}}};
                    toggle <= ~toggle;
                end else begin
                    rdata <= mem[index_of(rd_addr[ADDR_W-1:OFS_W], rd_addr[OFS_W-1:0])];
                end
            end
        end
    end

    AST_POLL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rdata[DATA_W-3:0] == '0)); // R8
endmodule

// File: rtl/page_write_store.sv
`timescale 1ns/1ps
module page_write_store
    import pw_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int GAP_US      = 100,
    parameter int PROG_US     = 10000,
    parameter int GAP_CYC     = CLK_MHZ * GAP_US,
    parameter int PROG_CYC    = CLK_MHZ * PROG_US,
    parameter int STORE_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [12:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy
);
    wr_req_t           req;
    logic [PAGE_W-1:0] open_page;
    logic              accept, first, loading, close, commit, last_b7;
    page_mask_t        mask;
    page_bytes_t       bytes;

    assign req = make_req(addr, wdata);

    pw_ctrl #(.GAP_CYC(GAP_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_page(req.page),
        .open_page(open_page), .accept(accept), .first(first),
        .loading(loading), .close(close), .commit(commit), .busy(busy)
    );

    pw_stage u_stage (
        .clk(clk), .rst(rst), .accept(accept), .first(first),
        .loading(loading), .busy(busy), .wr_en(wr_en), .req(req),
        .open_page(open_page), .mask(mask), .bytes(bytes), .last_b7(last_b7)
    );

    pw_array #(.STORE_PAGES(STORE_PAGES)) u_array (
        .clk(clk), .rst(rst), .commit(commit), .close(close), .busy(busy),
        .page(open_page), .mask(mask), .bytes(bytes), .last_b7(last_b7),
        .rd_en(rd_en), .rd_addr(addr), .rdata(rdata)
    );
endmodule

// File: tb/page_write_store_test.sv
`timescale 1ns/1ps
module page_write_store_test;
    localparam int GAP  = 8;
    localparam int PROG = 40;
    localparam int NV   = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;
    int          n_run = 0, n_fail = 0;

    page_write_store #(.GAP_CYC(GAP), .PROG_CYC(PROG), .STORE_PAGES(16)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #4 clk = ~clk;

    // kind: 0 write, 1 wait for programming to finish, 2 read and compare
    localparam logic [22:0] VECS [NV] = '{
        {2'd0, 13'h14A, 8'hA1},
        {2'd0, 13'h143, 8'h3C},
        {2'd0, 13'h14A, 8'h55},
        {2'd0, 13'h183, 8'h99},
        {2'd0, 13'h17F, 8'h7E},
        {2'd0, 13'h140, 8'h01},
        {2'd1, 13'h000, 8'h00},
        {2'd2, 13'h14A, 8'h55},
        {2'd2, 13'h143, 8'h3C},
        {2'd2, 13'h183, 8'hFF},
        {2'd2, 13'h17F, 8'h7E},
        {2'd2, 13'h140, 8'h01},
        {2'd2, 13'h141, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [12:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [12:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!busy && guard < 1000) begin @(negedge clk); guard++; end
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        string      tag;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 busy after reset", {7'd0, busy}, 8'h00);
        chk("R9 rdata after reset", rdata, 8'h00);
        do_rd(13'h000, v);
        chk("R9 R10 erased byte", v, 8'hFF);

        for (int k = 0; k < NV; k++) begin
            logic [1:0]  kind;
            logic [12:0] a;
            logic [7:0]  d;
            kind = VECS[k][22:21];
            a    = VECS[k][20:8];
            d    = VECS[k][7:0];
            if (kind == 2'd0) do_wr(a, d);
            else if (kind == 2'd1) wait_done();
            else begin
                if (a == 13'h14A)      tag = "R4 latest value";
                else if (a == 13'h183) tag = "R2 other page ignored";
                else if (a == 13'h141) tag = "R5 unloaded byte";
                else                   tag = "R1 R10 loaded byte";
                do_rd(a, v);
                chk(tag, v, d);
            end
        end

        // window close, status polling, busy length, write during busy
        do_wr(13'h2C5, 8'h00);
        idle(GAP - 1);
        chk("R3 busy low before gap expires", {7'd0, busy}, 8'h00);
        idle(1);
        chk("R3 busy high at gap expiry", {7'd0, busy}, 8'h01);
        do_rd(13'h2C5, v);
        chk("R8 first poll", v, 8'h80);
        do_rd(13'h000, v);
        chk("R8 second poll", v, 8'hC0);
        do_wr(13'h2C6, 8'h33);
        idle(PROG - 4);
        chk("R6 busy still high", {7'd0, busy}, 8'h01);
        idle(1);
        chk("R6 busy low after programming", {7'd0, busy}, 8'h00);
        do_rd(13'h2C5, v);
        chk("R6 committed byte", v, 8'h00);
        do_rd(13'h2C6, v);
        chk("R7 write during busy ignored", v, 8'hFF);

        // write exactly at the gap limit still joins the window
        do_wr(13'h080, 8'hAA);
        idle(GAP - 1);
        do_wr(13'h081, 8'hBB);
        chk("R3 window open after boundary write", {7'd0, busy}, 8'h00);
        wait_done();
        do_rd(13'h080, v);
        chk("R3 first boundary byte", v, 8'hAA);
        do_rd(13'h081, v);
        chk("R3 boundary byte kept", v, 8'hBB);

        // foreign-page write does not extend the window
        do_wr(13'h0C0, 8'h11);
        idle(GAP - 2);
        do_wr(13'h100, 8'h22);
        idle(1);
        chk("R2 foreign write does not extend", {7'd0, busy}, 8'h01);
        wait_done();
        do_rd(13'h0C0, v);
        chk("R2 open page byte", v, 8'h11);
        do_rd(13'h100, v);
        chk("R2 foreign byte ignored", v, 8'hFF);

        // page number folds modulo the stored page count
        do_wr(13'h5C2, 8'h5A);
        wait_done();
        do_rd(13'h1C2, v);
        chk("R1 page aliasing", v, 8'h5A);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule